// File: doc/BRIEF.md
# Performance Counter Event Priority Arbiter

This block sits beside a bank of event counters and decides, one action at a time, which counter event is serviced next. Each counter can raise two kinds of request: a precise-sample assist, which hands the counter to an external sample writer, and an overflow interrupt. General-purpose counters occupy the low indices of the request vectors and fixed counters the high ones. Lower indices always win, so every general-purpose counter outranks every fixed one. A request that loses arbitration is held in a sticky pending bit until it is granted.

Once an assist is granted, the arbiter grants nothing else until the sample writer reports completion on `sampleDone`. If the sample buffer reports that its threshold is reached at that moment, a threshold interrupt is issued next, ahead of every other request. After that, the assisted counter's own overflow interrupt can be granted. That counter therefore produces two distinct interrupt pulses. Overflow interrupts that are pending together are merged into a single pulse, and a mask names every counter included in it.

Top module: `pmu_evt_arbiter`

## Requirements
- R1: After reset, `grantVec` and `irqMask` are all zero, `grantAct` is 00, `irqPulse` is 0 and `irqCause` is 00.
- R2: Among pending counters, the lowest index is served first. General-purpose counters use indices 0..3 and fixed counters use indices 4..6, so any general-purpose request beats any fixed request.
- R3: A grant is a one-hot `grantVec` plus a `grantAct` code: 00 none, 01 assist, 10 threshold interrupt, 11 overflow interrupt. `irqPulse` is high for exactly the grant cycle of codes 10 and 11, and `irqCause` then carries that same code. An assist grant raises no interrupt.
- R4: A request is captured at the rising edge where it is high. When no other request is in the way, its grant is visible after the following rising edge and lasts one cycle.
- R5: A request that loses arbitration stays pending and is granted later without being repeated. Pending bits clear only when they are granted.
- R6: An overflow grant serves every counter that has an overflow pending and no assist pending. These counters produce one interrupt pulse, `irqMask` lists them, and `grantVec` marks the lowest of them.
- R7: When a counter has both an assist and an overflow pending, the assist is granted first.
- R8: After an assist grant, no grant of any kind is issued until `sampleDone` has been sampled high.
- R9: If `thresholdHit` is high in the cycle `sampleDone` completes an assist, a threshold interrupt for the assisted counter is granted one cycle after that edge, before any other pending request. That counter's pending overflow follows as a separate pulse.
- R10: `ovfReq[i]` is ignored while `intEn[i]` is 0, and `preciseReq[i]` is ignored while `preciseEn[i]` is 0.
- R11: `sampleDone` and `thresholdHit` have no effect while no assist is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ovfReq | input | 7 | Per-counter overflow request strobes |
| preciseReq | input | 7 | Per-counter precise-sample assist request strobes |
| intEn | input | 7 | Per-counter overflow interrupt enable |
| preciseEn | input | 7 | Per-counter precise sampling enable |
| sampleDone | input | 1 | Sample writer finished the outstanding assist |
| thresholdHit | input | 1 | Sample buffer threshold reached |
| grantVec | output | 7 | One-hot counter chosen this cycle |
| grantAct | output | 2 | Action code of the grant |
| irqPulse | output | 1 | Single-cycle interrupt pulse |
| irqCause | output | 2 | Interrupt cause, same code as the grant |
| irqMask | output | 7 | Counters covered by this interrupt |

## Verification
The hardest case to reach is a single counter that walks the full chain: assist, then busy wait, then threshold interrupt, then its own overflow. A lower-ranked overflow must arrive during the wait and be merged into that final overflow pulse. The bench raises the assist and the overflow for counter 0 in the same cycle. It injects a second overflow while the arbiter is stalled, then completes the assist with the threshold flag set. It checks every cycle of the chain against the expected codes and masks.

// File: rtl/pmu_arb_pkg.sv
package pmu_arb_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_ASSIST = 2'b01,
    ACT_THRESH = 2'b10,
    ACT_OVF    = 2'b11
  } act_e;

  typedef struct packed {
    logic takeAssist;
    logic takeOvf;
  } strobe_t;

endpackage

// File: rtl/pmu_arb_dp.sv
module pmu_arb_dp
  import pmu_arb_pkg::*;
#(
  parameter int NUM_CTR = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CTR-1:0] ovfReq,
  input  logic [NUM_CTR-1:0] preciseReq,
  input  logic [NUM_CTR-1:0] intEn,
  input  logic [NUM_CTR-1:0] preciseEn,
  input  strobe_t            strobe,
  output logic [NUM_CTR-1:0] winner,
  output logic               winIsAssist,
  output logic               anyPend,
  output logic [NUM_CTR-1:0] mergeMask
);

  logic [NUM_CTR-1:0] assistPend;
  logic [NUM_CTR-1:0] ovfPend;
  logic [NUM_CTR-1:0] eitherPend;
  logic               takeAssist;
  logic               takeOvf;

  assign takeAssist = strobe.takeAssist;
  assign takeOvf    = strobe.takeOvf;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        assistPend[i] <= 1'b0;
        ovfPend[i]    <= 1'b0;
      end else begin
        assistPend[i] <= (assistPend[i] & ~(takeAssist & winner[i]))
                         | (preciseReq[i] & preciseEn[i]);
        ovfPend[i]    <= (ovfPend[i] & ~(takeOvf & mergeMask[i]))
                         | (ovfReq[i] & intEn[i]);
      end
    end

    // pending bits leave only through a grant
    p_assist_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(assistPend[i]) |-> $past(takeAssist && winner[i]));
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ovfPend[i]) |-> $past(takeOvf && mergeMask[i]));
  end

  // lowest index wins; general-purpose counters sit at the low indices
  assign eitherPend  = assistPend | ovfPend;
  assign anyPend     = |eitherPend;
  assign winner      = eitherPend & (~eitherPend + NUM_CTR'(1));
  assign winIsAssist = |(winner & assistPend);
  // overflows merge, but never ahead of their own counter's assist
  assign mergeMask   = ovfPend & ~assistPend;

endmodule

// File: rtl/pmu_arb_ctl.sv
module pmu_arb_ctl
  import pmu_arb_pkg::*;
#(
  parameter int NUM_CTR = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CTR-1:0] winner,
  input  logic               winIsAssist,
  input  logic               anyPend,
  input  logic [NUM_CTR-1:0] mergeMask,
  input  logic               sampleDone,
  input  logic               thresholdHit,
  output strobe_t            strobe,
  output logic [NUM_CTR-1:0] grantVec,
  output logic [1:0]         grantAct,
  output logic               irqPulse,
  output logic [1:0]         irqCause,
  output logic [NUM_CTR-1:0] irqMask
);

  logic               busy;
  logic               thrPend;
  logic [NUM_CTR-1:0] thrVec;
  logic               mayGrant;

  assign mayGrant          = !busy && !thrPend && anyPend;
  assign strobe.takeAssist = mayGrant && winIsAssist;
  assign strobe.takeOvf    = mayGrant && !winIsAssist;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      thrPend  <= 1'b0;
      thrVec   <= '0;
      grantVec <= '0;
      grantAct <= ACT_NONE;
      irqPulse <= 1'b0;
      irqCause <= ACT_NONE;
      irqMask  <= '0;
    end else begin
      grantVec <= '0;
      grantAct <= ACT_NONE;
      irqPulse <= 1'b0;
      irqCause <= ACT_NONE;
      irqMask  <= '0;
      if (thrPend) begin
        thrPend  <= 1'b0;
        grantVec <= thrVec;
        grantAct <= ACT_THRESH;
        irqPulse <= 1'b1;
        irqCause <= ACT_THRESH;
        irqMask  <= thrVec;
      end else if (strobe.takeAssist) begin
        busy     <= 1'b1;
        thrVec   <= winner;
        grantVec <= winner;
        grantAct <= ACT_ASSIST;
      end else if (strobe.takeOvf) begin
        grantVec <= winner;
        grantAct <= ACT_OVF;
        irqPulse <= 1'b1;
        irqCause <= ACT_OVF;
        irqMask  <= mergeMask;
      end
      if (busy && sampleDone) begin
        busy    <= 1'b0;
        thrPend <= thresholdHit;
      end
    end
  end

  p_onehot_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && ((grantAct == ACT_NONE) == (grantVec == '0)));
  p_irq_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (irqCause == grantAct && grantAct != ACT_ASSIST));
  p_busy_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (grantAct == ACT_NONE));
  p_thresh_after_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (grantAct == ACT_THRESH) |-> $past(sampleDone && thresholdHit, 2));
  p_merge_lowest_r6: assert property (@(posedge clk) disable iff (!rstN)
    (grantAct == ACT_OVF) |-> (((irqMask & grantVec) == grantVec)
                              && ((irqMask & (grantVec - NUM_CTR'(1))) == '0)));

endmodule

// File: rtl/pmu_evt_arbiter.sv
module pmu_evt_arbiter
  import pmu_arb_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  localparam int NUM_CTR = NUM_GP + NUM_FIX
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CTR-1:0] ovfReq,
  input  logic [NUM_CTR-1:0] preciseReq,
  input  logic [NUM_CTR-1:0] intEn,
  input  logic [NUM_CTR-1:0] preciseEn,
  input  logic               sampleDone,
  input  logic               thresholdHit,
  output logic [NUM_CTR-1:0] grantVec,
  output logic [1:0]         grantAct,
  output logic               irqPulse,
  output logic [1:0]         irqCause,
  output logic [NUM_CTR-1:0] irqMask
);

  strobe_t            strobe;
  logic [NUM_CTR-1:0] winner;
  logic [NUM_CTR-1:0] mergeMask;
  logic               winIsAssist;
  logic               anyPend;

  pmu_arb_dp #(.NUM_CTR(NUM_CTR)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ovfReq     (ovfReq),
    .preciseReq (preciseReq),
    .intEn      (intEn),
    .preciseEn  (preciseEn),
    .strobe     (strobe),
    .winner     (winner),
    .winIsAssist(winIsAssist),
    .anyPend    (anyPend),
    .mergeMask  (mergeMask)
  );

  pmu_arb_ctl #(.NUM_CTR(NUM_CTR)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .winner      (winner),
    .winIsAssist (winIsAssist),
    .anyPend     (anyPend),
    .mergeMask   (mergeMask),
    .sampleDone  (sampleDone),
    .thresholdHit(thresholdHit),
    .strobe      (strobe),
    .grantVec    (grantVec),
    .grantAct    (grantAct),
    .irqPulse    (irqPulse),
    .irqCause    (irqCause),
    .irqMask     (irqMask)
  );

endmodule

// File: tb/sim_pmu_evt_arbiter.sv
module sim_pmu_evt_arbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [6:0] ovfReq, preciseReq, intEn, preciseEn;
  logic       sampleDone, thresholdHit;
  logic [6:0] grantVec, irqMask;
  logic [1:0] grantAct, irqCause;
  logic       irqPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_evt_arbiter u0 (
    .clk(clk), .rstN(rstN), .ovfReq(ovfReq), .preciseReq(preciseReq),
    .intEn(intEn), .preciseEn(preciseEn), .sampleDone(sampleDone),
    .thresholdHit(thresholdHit), .grantVec(grantVec), .grantAct(grantAct),
    .irqPulse(irqPulse), .irqCause(irqCause), .irqMask(irqMask)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // full output picture: vector, action, pulse, cause, mask
  task automatic chkOut(string tag, int gv, int act, int irq, int cause, int msk);
    chk({tag, " grantVec"}, int'(grantVec), gv);
    chk({tag, " grantAct"}, int'(grantAct), act);
    chk({tag, " irqPulse"}, int'(irqPulse), irq);
    chk({tag, " irqCause"}, int'(irqCause), cause);
    chk({tag, " irqMask"},  int'(irqMask),  msk);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearIn();
    ovfReq = '0; preciseReq = '0; sampleDone = 0; thresholdHit = 0;
  endtask

  task automatic doneAssist(bit thr);
    sampleDone = 1; thresholdHit = thr;
    tick();
    sampleDone = 0; thresholdHit = 0;
  endtask

  task automatic t_reset();
    rstN = 0; clearIn(); intEn = '1; preciseEn = '1;
    repeat (3) tick();
    rstN = 1;
    tick();
    chkOut("R1 reset", 0, 0, 0, 0, 0);
  endtask

  // ovf on 1, ovf on fixed 4, assist on 2, all in one cycle
  task automatic t_priority();
    ovfReq = 7'b0010010; preciseReq = 7'b0000100;
    tick(); clearIn();
    tick();
    chkOut("R2 R4 R6 merged ovf", 7'b0000010, 3, 1, 3, 7'b0010010);
    tick();
    chkOut("R2 R3 assist ctr2", 7'b0000100, 1, 0, 0, 0);
    tick();
    chkOut("R8 busy stall", 0, 0, 0, 0, 0);
    tick();
    chkOut("R8 busy stall 2", 0, 0, 0, 0, 0);
    doneAssist(0);
    chkOut("R8 done edge", 0, 0, 0, 0, 0);
    tick();
    chkOut("R4 idle after done", 0, 0, 0, 0, 0);
  endtask

  // assist on GP counter 3 beats overflow on fixed counter 6; 6 waits
  task automatic t_gp_vs_fixed();
    ovfReq = 7'b1000000; preciseReq = 7'b0001000;
    tick(); clearIn();
    tick();
    chkOut("R2 gp before fixed", 7'b0001000, 1, 0, 0, 0);
    doneAssist(0);
    chkOut("R8 stall until done", 0, 0, 0, 0, 0);
    tick();
    chkOut("R5 held fixed ovf", 7'b1000000, 3, 1, 3, 7'b1000000);
    tick();
    chkOut("R4 one cycle grant", 0, 0, 0, 0, 0);
  endtask

  // disabled requests and stray done/threshold do nothing
  task automatic t_masked();
    intEn = 7'b1111110; preciseEn = 7'b1111101;
    ovfReq = 7'b0000001; preciseReq = 7'b0000010;
    tick(); clearIn();
    sampleDone = 1; thresholdHit = 1;
    tick(); clearIn();
    chkOut("R10 R11 masked", 0, 0, 0, 0, 0);
    tick();
    chkOut("R10 R11 masked 2", 0, 0, 0, 0, 0);
    tick();
    chkOut("R11 no thresh", 0, 0, 0, 0, 0);
    intEn = '1; preciseEn = '1;
    tick();
    chkOut("R10 nothing latched", 0, 0, 0, 0, 0);
  endtask

  // counter 0: assist + ovf, threshold met, ovf on 1 arrives while busy
  task automatic t_chain();
    ovfReq = 7'b0000001; preciseReq = 7'b0000001;
    tick(); clearIn();
    tick();
    chkOut("R7 assist first", 7'b0000001, 1, 0, 0, 0);
    ovfReq = 7'b0000010;
    tick(); ovfReq = '0;
    chkOut("R8 stall", 0, 0, 0, 0, 0);
    doneAssist(1);
    chkOut("R9 done edge", 0, 0, 0, 0, 0);
    tick();
    chkOut("R9 thresh irq", 7'b0000001, 2, 1, 2, 7'b0000001);
    tick();
    chkOut("R9 R6 ovf after thresh", 7'b0000001, 3, 1, 3, 7'b0000011);
    tick();
    chkOut("R5 all served", 0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_gp_vs_fixed();
    t_masked();
    t_chain();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule